// File: doc/BRIEF.md
# Dual-Bus DSP Operand Transfer Unit

This block moves 16-bit words between a six-entry DSP register set and two independent on-chip data memories, called X and Y, each reached over its own port. A decoded transfer command carries, for each side, an operation (idle, load or store), a register select and a word address. Both sides act in the same cycle without affecting each other. A store sends the upper half of an accumulator to memory. A load returns a memory word that is written into the upper half of a data register one cycle later, with the lower half cleared.

The unit merges its load write-backs with the ALU's register write-back into one set of per-register write enables and data. When both target the same register in the same cycle, the load wins and a conflict flag is raised. The unit also tells the issue logic whether the command may run alongside an ALU operation: it may only when the command comes in the longer, parallel form. The status-register write enable is driven by the ALU alone, so transfers never touch the condition bits.

Top module: `dsp_xy_mover`

## Requirements
- R1: The X and Y sides act independently in the same cycle. A legal load or store on a side raises that side's memory enable, with its command address, in the command cycle.
- R2: Register codes are X0=0, X1=1, Y0=2, Y1=3, A0=4, A1=5, and op codes are 0 idle, 1 load, 2 store, 3 reserved. An X load may target only codes 0 or 1, and a Y load only codes 2 or 3.
- R3: A store is legal only from code 4 or 5. It writes bits 31:16 of that accumulator to the addressed word in the command cycle, with the write enable high.
- R4: A legal load writes {memory word, 16'h0000} into its target register in the cycle after the command.
- R5: An illegal select, or op 3, produces no memory access on that side and raises that side's error output for the command cycle. The other side is not affected.
- R6: `sr_we` equals `alu_sr_we` in every cycle, whatever transfers are under way.
- R7: `alu_par_ok` is 1 exactly when `cmd_valid` and `cmd_par` are both 1.
- R8: An ALU write to register code 0..5 appears on `rf_we`/`rf_wdata` in the same cycle. If a load writes the same register in that cycle, the load data is written and `wb_conflict` is 1 for that cycle only.
- R9: While `rst_n` is low, commands cause no memory access and no error, and any pending load is dropped, so no register write follows.
- R10: A side whose op is 0 performs no memory access and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Transfer command present |
| cmd_par | input | 1 | 1 = parallel form, 0 = transfer-only form |
| cmd_x_op | input | 2 | X-side operation |
| cmd_x_reg | input | 3 | X-side register select |
| cmd_x_addr | input | AW | X-side word address |
| cmd_y_op | input | 2 | Y-side operation |
| cmd_y_reg | input | 3 | Y-side register select |
| cmd_y_addr | input | AW | Y-side word address |
| acc_a0_hi | input | WW | Upper half of accumulator A0 |
| acc_a1_hi | input | WW | Upper half of accumulator A1 |
| alu_we | input | 1 | ALU register write request |
| alu_reg | input | 3 | ALU target register code |
| alu_wdata | input | 2*WW | ALU write data |
| alu_sr_we | input | 1 | ALU status-register update request |
| xm_en | output | 1 | X memory access enable |
| xm_we | output | 1 | X memory write enable |
| xm_addr | output | AW | X memory address |
| xm_wdata | output | WW | X memory write data |
| xm_rdata | input | WW | X memory read data, one cycle after the address |
| ym_en | output | 1 | Y memory access enable |
| ym_we | output | 1 | Y memory write enable |
| ym_addr | output | AW | Y memory address |
| ym_wdata | output | WW | Y memory write data |
| ym_rdata | input | WW | Y memory read data, one cycle after the address |
| rf_we | output | 6 | Per-register write enable |
| rf_wdata | output | 6*2*WW | Per-register write data, register i at bits i*2*WW upward |
| wb_conflict | output | 1 | Load and ALU hit the same register this cycle |
| err_x | output | 1 | X-side command rejected |
| err_y | output | 1 | Y-side command rejected |
| alu_par_ok | output | 1 | ALU operation may run with this command |
| sr_we | output | 1 | Status-register write enable |

## Verification
The memory enables, store data, error pulses, `alu_par_ok` and `sr_we` all respond in the command cycle. A load's register write and any conflict it causes appear in the following cycle. The bench drives inputs at the falling edge and samples 1 ns later. The write-back it expects in each window is the load it recorded one cycle earlier, merged with the ALU write it drives in that window. The bench also holds an environment register file and memories that are updated only from the block's outputs, and compares them with its reference state every cycle and at the end.

// File: rtl/dxy_pkg.sv
package dxy_pkg;
    localparam int NREG = 6;
    localparam int RSW  = 3;

    typedef enum logic [1:0] {
        XOP_NONE  = 2'd0,
        XOP_LOAD  = 2'd1,
        XOP_STORE = 2'd2,
        XOP_RSVD  = 2'd3
    } xop_e;

    localparam logic [RSW-1:0] R_X0 = 3'd0;
    localparam logic [RSW-1:0] R_X1 = 3'd1;
    localparam logic [RSW-1:0] R_Y0 = 3'd2;
    localparam logic [RSW-1:0] R_Y1 = 3'd3;
    localparam logic [RSW-1:0] R_A0 = 3'd4;
    localparam logic [RSW-1:0] R_A1 = 3'd5;
endpackage

// File: rtl/dxy_side.sv
module dxy_side
    import dxy_pkg::*;
#(
    parameter int AW = 8,
    parameter int WW = 16,
    parameter logic [RSW-1:0] LD_BASE = R_X0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     op,
    input  logic [RSW-1:0] sel,
    input  logic [AW-1:0]  addr,
    input  logic [WW-1:0]  acc0_hi,
    input  logic [WW-1:0]  acc1_hi,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [WW-1:0]  mem_wdata,
    input  logic [WW-1:0]  mem_rdata,
    output logic           err,
    output logic           ld_vld,
    output logic [RSW-1:0] ld_sel,
    output logic [2*WW-1:0] ld_data
);
    localparam logic [RSW-1:0] LD_NEXT = LD_BASE + 3'd1;

    typedef struct packed {
        logic           vld;
        logic [RSW-1:0] sel;
    } pend_t;

    pend_t pend_d, pend_q;
    logic  act, ld_ok, st_ok;

    always_comb begin
        pend_d    = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr;
        mem_wdata = '0;
        err       = 1'b0;
        act       = cmd_valid && rst_n;
        ld_ok     = (sel == LD_BASE) || (sel == LD_NEXT);
        st_ok     = (sel == R_A0) || (sel == R_A1);
        if (act) begin
            unique case (xop_e'(op))
                XOP_NONE: ;
                XOP_LOAD: begin
                    if (ld_ok) begin
                        mem_en     = 1'b1;
                        pend_d.vld = 1'b1;
                        pend_d.sel = sel;
                    end else begin
                        err = 1'b1;
                    end
                end
                XOP_STORE: begin
                    if (st_ok) begin
                        mem_en    = 1'b1;
                        mem_we    = 1'b1;
                        mem_wdata = (sel == R_A0) ? acc0_hi : acc1_hi;
                    end else begin
                        err = 1'b1;
                    end
                end
                default: err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign ld_vld  = pend_q.vld;
    assign ld_sel  = pend_q.sel;
    assign ld_data = {mem_rdata, {WW{1'b0}}};

    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_en) else $error("rejected side accessed memory"); // R5
    AST_LOAD_WB_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (ld_vld && ld_sel == $past(sel))) else $error("load not written back"); // R4
    AST_LD_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld |-> (ld_sel == LD_BASE || ld_sel == LD_NEXT)) else $error("load target outside side pair"); // R2
    AST_STORE_FROM_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sel == R_A0 || sel == R_A1)) else $error("store from non-accumulator"); // R3
endmodule

// File: rtl/dxy_wb_merge.sv
module dxy_wb_merge #(
    parameter int NR = 6,
    parameter int RW = 32,
    parameter int SW = 3
) (
    input  logic           x_vld,
    input  logic [SW-1:0]  x_sel,
    input  logic [RW-1:0]  x_data,
    input  logic           y_vld,
    input  logic [SW-1:0]  y_sel,
    input  logic [RW-1:0]  y_data,
    input  logic           alu_we,
    input  logic [SW-1:0]  alu_sel,
    input  logic [RW-1:0]  alu_data,
    output logic [NR-1:0]  rf_we,
    output logic [NR*RW-1:0] rf_wdata,
    output logic           conflict
);
    for (genvar g = 0; g < NR; g++) begin : g_reg
        logic hit_x, hit_y, hit_a;
        assign hit_x = x_vld && (x_sel == SW'(g));
        assign hit_y = y_vld && (y_sel == SW'(g));
        assign hit_a = alu_we && (alu_sel == SW'(g));
        assign rf_we[g] = hit_x || hit_y || hit_a;
        assign rf_wdata[g*RW +: RW] = hit_x ? x_data : (hit_y ? y_data : alu_data);
    end

    assign conflict = alu_we && ((x_vld && x_sel == alu_sel) || (y_vld && y_sel == alu_sel));
endmodule

// File: rtl/dsp_xy_mover.sv
module dsp_xy_mover
    import dxy_pkg::*;
#(
    parameter int AW = 8,
    parameter int WW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_par,
    input  logic [1:0]           cmd_x_op,
    input  logic [RSW-1:0]       cmd_x_reg,
    input  logic [AW-1:0]        cmd_x_addr,
    input  logic [1:0]           cmd_y_op,
    input  logic [RSW-1:0]       cmd_y_reg,
    input  logic [AW-1:0]        cmd_y_addr,
    input  logic [WW-1:0]        acc_a0_hi,
    input  logic [WW-1:0]        acc_a1_hi,
    input  logic                 alu_we,
    input  logic [RSW-1:0]       alu_reg,
    input  logic [2*WW-1:0]      alu_wdata,
    input  logic                 alu_sr_we,
    output logic                 xm_en,
    output logic                 xm_we,
    output logic [AW-1:0]        xm_addr,
    output logic [WW-1:0]        xm_wdata,
    input  logic [WW-1:0]        xm_rdata,
    output logic                 ym_en,
    output logic                 ym_we,
    output logic [AW-1:0]        ym_addr,
    output logic [WW-1:0]        ym_wdata,
    input  logic [WW-1:0]        ym_rdata,
    output logic [NREG-1:0]      rf_we,
    output logic [NREG*2*WW-1:0] rf_wdata,
    output logic                 wb_conflict,
    output logic                 err_x,
    output logic                 err_y,
    output logic                 alu_par_ok,
    output logic                 sr_we
);
    localparam int RW = 2 * WW;

    logic           x_ld_vld, y_ld_vld;
    logic [RSW-1:0] x_ld_sel, y_ld_sel;
    logic [RW-1:0]  x_ld_data, y_ld_data;

    dxy_side #(.AW(AW), .WW(WW), .LD_BASE(R_X0)) u_side_x (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .op(cmd_x_op), .sel(cmd_x_reg), .addr(cmd_x_addr),
        .acc0_hi(acc_a0_hi), .acc1_hi(acc_a1_hi),
        .mem_en(xm_en), .mem_we(xm_we), .mem_addr(xm_addr),
        .mem_wdata(xm_wdata), .mem_rdata(xm_rdata), .err(err_x),
        .ld_vld(x_ld_vld), .ld_sel(x_ld_sel), .ld_data(x_ld_data)
    );

    dxy_side #(.AW(AW), .WW(WW), .LD_BASE(R_Y0)) u_side_y (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .op(cmd_y_op), .sel(cmd_y_reg), .addr(cmd_y_addr),
        .acc0_hi(acc_a0_hi), .acc1_hi(acc_a1_hi),
        .mem_en(ym_en), .mem_we(ym_we), .mem_addr(ym_addr),
        .mem_wdata(ym_wdata), .mem_rdata(ym_rdata), .err(err_y),
        .ld_vld(y_ld_vld), .ld_sel(y_ld_sel), .ld_data(y_ld_data)
    );

    dxy_wb_merge #(.NR(NREG), .RW(RW), .SW(RSW)) u_merge (
        .x_vld(x_ld_vld), .x_sel(x_ld_sel), .x_data(x_ld_data),
        .y_vld(y_ld_vld), .y_sel(y_ld_sel), .y_data(y_ld_data),
        .alu_we(alu_we), .alu_sel(alu_reg), .alu_data(alu_wdata),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .conflict(wb_conflict)
    );

    assign alu_par_ok = cmd_valid && cmd_par;
    assign sr_we      = alu_sr_we;

    AST_PAR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        alu_par_ok |-> cmd_valid) else $error("parallel flag without command"); // R7
    AST_CONFLICT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_conflict |-> (alu_we && (x_ld_vld || y_ld_vld))) else $error("conflict without load"); // R8
endmodule

// File: tb/test_dsp_xy_mover.sv
module test_dsp_xy_mover;
    localparam int AW = 8, WW = 16, RW = 32, NR = 6, DEPTH = 256;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cmd_valid = 0, cmd_par = 0, alu_we = 0, alu_sr_we = 0;
    logic [1:0] cmd_x_op = 0, cmd_y_op = 0;
    logic [2:0] cmd_x_reg = 0, cmd_y_reg = 0, alu_reg = 0;
    logic [AW-1:0] cmd_x_addr = 0, cmd_y_addr = 0;
    logic [RW-1:0] alu_wdata = 0;
    logic [WW-1:0] acc_a0_hi, acc_a1_hi, xm_wdata, ym_wdata;
    logic [WW-1:0] xm_rdata = 0, ym_rdata = 0;
    logic xm_en, xm_we, ym_en, ym_we, wb_conflict, err_x, err_y, alu_par_ok, sr_we;
    logic [AW-1:0] xm_addr, ym_addr;
    logic [NR-1:0] rf_we;
    logic [NR*RW-1:0] rf_wdata;

    dsp_xy_mover #(.AW(AW), .WW(WW)) i_dsp_xy_mover (.*);

    // environment: memories and register file driven only by the block's outputs
    logic [WW-1:0] memx [DEPTH];
    logic [WW-1:0] memy [DEPTH];
    logic [RW-1:0] rf   [NR];

    function automatic logic [WW-1:0] pat(int i, int side);
        return WW'(i * 40503) ^ (side != 0 ? 16'h5a5a : 16'h0c3c);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin memx[i] <= pat(i, 0); memy[i] <= pat(i, 1); end
            for (int i = 0; i < NR; i++) rf[i] <= '0;
        end else begin
            if (xm_en) begin if (xm_we) memx[xm_addr] <= xm_wdata; else xm_rdata <= memx[xm_addr]; end
            if (ym_en) begin if (ym_we) memy[ym_addr] <= ym_wdata; else ym_rdata <= memy[ym_addr]; end
            for (int i = 0; i < NR; i++) if (rf_we[i]) rf[i] <= rf_wdata[i*RW +: RW];
        end
    end
    assign acc_a0_hi = rf[4][31:16];
    assign acc_a1_hi = rf[5][31:16];

    // reference model
    logic [WW-1:0] refx [DEPTH];
    logic [WW-1:0] refy [DEPTH];
    logic [RW-1:0] rrf  [NR];
    bit pxv, pyv;
    logic [2:0] pxs, pys;
    logic [WW-1:0] pxw, pyw;
    int checks = 0, fails = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit legal(int side, logic [1:0] op, logic [2:0] sel);
        case (op)
            2'd0: return 1;
            2'd1: return side == 0 ? (sel == 0 || sel == 1) : (sel == 2 || sel == 3);
            2'd2: return sel == 4 || sel == 5;
            default: return 0;
        endcase
    endfunction

    task automatic cyc(input bit rs, input bit v, input bit par,
                       input logic [1:0] xo, input logic [2:0] xs, input logic [AW-1:0] xa,
                       input logic [1:0] yo, input logic [2:0] ys, input logic [AW-1:0] ya,
                       input bit awe, input logic [2:0] asel, input logic [RW-1:0] adat, input bit asr);
        logic [NR-1:0] ewe;
        logic [RW-1:0] ed [NR];
        bit econf, xgo, ygo;
        @(negedge clk);
        rst_n = rs; cmd_valid = v; cmd_par = par;
        cmd_x_op = xo; cmd_x_reg = xs; cmd_x_addr = xa;
        cmd_y_op = yo; cmd_y_reg = ys; cmd_y_addr = ya;
        alu_we = awe; alu_reg = asel; alu_wdata = adat; alu_sr_we = asr;
        #1;
        if (!rs) begin
            pxv = 0; pyv = 0;
            for (int i = 0; i < DEPTH; i++) begin refx[i] = pat(i, 0); refy[i] = pat(i, 1); end
            for (int i = 0; i < NR; i++) rrf[i] = '0;
        end else begin
            for (int i = 0; i < NR; i++) chk("R4 regfile", rf[i], rrf[i]);
        end
        // command-cycle outputs
        xgo = rs && v && xo != 0 && legal(0, xo, xs);
        ygo = rs && v && yo != 0 && legal(1, yo, ys);
        chk(!rs ? "R9 err_x" : "R5 err_x", err_x, rs && v && !legal(0, xo, xs));
        chk(!rs ? "R9 err_y" : "R5 err_y", err_y, rs && v && !legal(1, yo, ys));
        chk(!rs ? "R9 xm_en" : (xo == 0 ? "R10 xm_en" : "R1 xm_en"), xm_en, xgo);
        chk(!rs ? "R9 ym_en" : (yo == 0 ? "R10 ym_en" : "R1 ym_en"), ym_en, ygo);
        if (xgo) begin
            chk("R1 xm_addr", xm_addr, xa);
            chk("R3 xm_we", xm_we, xo == 2);
            if (xo == 2) chk("R3 xm_wdata", xm_wdata, rrf[xs][31:16]);
        end
        if (ygo) begin
            chk("R1 ym_addr", ym_addr, ya);
            chk("R3 ym_we", ym_we, yo == 2);
            if (yo == 2) chk("R3 ym_wdata", ym_wdata, rrf[ys][31:16]);
        end
        chk("R7 alu_par_ok", alu_par_ok, v && par);
        chk("R6 sr_we", sr_we, asr);
        // write-back window
        ewe = '0; econf = 0;
        for (int i = 0; i < NR; i++) ed[i] = '0;
        if (awe && asel < NR) begin ewe[asel] = 1; ed[asel] = adat; end
        if (pxv) begin if (awe && asel == pxs) econf = 1; ewe[pxs] = 1; ed[pxs] = {pxw, 16'h0}; end
        if (pyv) begin if (awe && asel == pys) econf = 1; ewe[pys] = 1; ed[pys] = {pyw, 16'h0}; end
        chk(!rs ? "R9 rf_we" : "R4 rf_we", rf_we, ewe);
        chk("R8 wb_conflict", wb_conflict, econf);
        for (int i = 0; i < NR; i++)
            if (ewe[i]) chk("R8 rf_wdata", rf_wdata[i*RW +: RW], ed[i]);
        // advance model
        pxv = xgo && xo == 1; pxs = xs; pxw = refx[xa];
        pyv = ygo && yo == 1; pys = ys; pyw = refy[ya];
        if (xgo && xo == 2) refx[xa] = rrf[xs][31:16];
        if (ygo && yo == 2) refy[ya] = rrf[ys][31:16];
        if (rs) for (int i = 0; i < NR; i++) if (ewe[i]) rrf[i] = ed[i];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // reset: commands ignored (R9)
        cyc(0, 1, 1, 1, 0, 8'h10, 2, 1, 8'h11, 0, 0, 0, 0);
        cyc(0, 1, 0, 3, 4, 8'h12, 1, 4, 8'h13, 0, 0, 0, 0);
        // load A0/A1 through the ALU path (R8), sr_we follows ALU (R6)
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 32'hA0A0_1234, 1);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 32'hB1B1_5678, 0);
        // dual load X0 and Y1 in one cycle (R1, R2, R4), transfer-only form
        cyc(1, 1, 0, 1, 0, 8'h05, 1, 3, 8'h09, 0, 0, 0, 0);
        // dual store A0 to X, A1 to Y, parallel form, ALU sr update (R3, R6, R7)
        cyc(1, 1, 1, 2, 4, 8'h20, 2, 5, 8'h21, 0, 0, 0, 1);
        // read back stored words (R3)
        cyc(1, 1, 0, 1, 1, 8'h20, 1, 2, 8'h21, 0, 0, 0, 0);
        // illegal selects and reserved op (R5), X-only and Y-only moves (R10)
        cyc(1, 1, 0, 1, 4, 8'h30, 2, 1, 8'h31, 0, 0, 0, 0);
        cyc(1, 1, 0, 3, 0, 8'h32, 1, 2, 8'h33, 0, 0, 0, 0);
        cyc(1, 1, 0, 1, 2, 8'h34, 0, 0, 8'h35, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 8'h36, 1, 0, 8'h37, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 8'h38, 1, 3, 8'h39, 0, 0, 0, 0);
        // conflict: load X1, next cycle ALU writes X1 (R8)
        cyc(1, 1, 0, 1, 1, 8'h40, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'hDEAD_BEEF, 0);
        // mid-run reset drops a pending load (R9)
        cyc(1, 1, 0, 1, 0, 8'h41, 1, 2, 8'h42, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // random stream
        for (int n = 0; n < 3000; n++) begin
            cyc(1, $urandom_range(0, 9) != 0, 1'($urandom),
                2'($urandom), 3'($urandom_range(0, 7)), AW'($urandom),
                2'($urandom), 3'($urandom_range(0, 7)), AW'($urandom),
                $urandom_range(0, 2) == 0, 3'($urandom_range(0, 7)), $urandom, 1'($urandom));
        end
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 memx", memx[i], refx[i]);
            chk("R3 memy", memy[i], refy[i]);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule